// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block is a slave-only serial audio receiver. It watches an externally driven bit clock, word strobe and data line, all already brought into the system clock domain. From these it recovers parallel samples. Each sample is sign-extended to 32 bits and comes out with a one-cycle valid strobe and a channel number.

A 16-bit configuration word sets the framing. It holds a coded sample length, a bit that places the data at the start or at the end of each strobe slot, the strobe level that marks the first channel, and a bit that makes the strobe change one bit clock ahead of the word. A mode bit switches between a two-channel stream, with one sample per strobe half, and a multichannel frame. In a multichannel frame up to eight back-to-back words follow a single strobe pulse. Frames whose word count is too high or odd raise a sticky error flag.

Top module: `serial_audio_rx`

## Requirements
- R1: Data is taken MSB first on bit-clock rising edges. The sample length n is set by cfg[3:0] as n = 2*field + 2, for field values 7 to 15: 7 gives 16 bits, 8 gives 18 bits, 15 gives 32 bits.
- R2: Every sample is sign-extended from bit n-1 to the 32-bit smp_data output.
- R3: With cfg[11]=0 (start alignment), a sample is the first n bits of its slot. Any later bits in the slot have no effect on the output.
- R4: With cfg[11]=1 (end alignment), a sample is the last n bits of its slot. Any earlier bits in the slot have no effect on the output.
- R5: cfg[10] gives the strobe level of channel 0. With 0, a low strobe marks channel 0; with 1, a high strobe marks channel 0.
- R6: With cfg[9]=0, the strobe changes on the first bit of a slot. With cfg[9]=1, it changes on the last bit of the previous slot.
- R7: With cfg[8]=0 (two-channel mode), each slot yields one sample on channel 0 or 1. The sample appears at the bit-clock rise that carries the first bit of the following slot. The slot that is open at the first strobe change after reset yields nothing. smp_valid is a single-cycle pulse.
- R8: With cfg[8]=1 (multichannel mode), a frame starts where the strobe enters the channel-0 level. Frames are built from consecutive n-bit words on channels 0, 1, 2 and up. Each word appears at the rise that carries its last bit. Strobe changes to the other level do not split words.
- R9: In multichannel mode, words after the eighth in a frame are discarded, and fmt_err is set.
- R10: A frame that ends with an odd word count sets fmt_err when the next frame starts. fmt_err stays set until reset.
- R11: During and after reset, smp_valid, smp_chan, smp_data and fmt_err are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 16 | Format configuration word |
| sck | input | 1 | Bit clock, synchronous to clk |
| ws | input | 1 | Word strobe, synchronous to clk |
| sd | input | 1 | Serial data, synchronous to clk |
| smp_valid | output | 1 | One-cycle pulse per sample |
| smp_chan | output | 3 | Channel index of the sample |
| smp_data | output | 32 | Sign-extended sample |
| fmt_err | output | 1 | Sticky multichannel framing error |

## Verification
Each result is registered on the clock edge that first sees the bit-clock rise that completes it. In two-channel mode this is the first bit of the next slot. In multichannel mode it is the word's last bit, and an odd-count error appears on the first bit of the next frame. The bench drives the bit clock at falling edges and records every valid pulse at falling edges. Each test therefore ends with a trailing bit that closes the last slot or opens the next frame, then compares the recorded list in order. The odd-count error is read once before that trailing bit and once after it.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int MAX_CH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg,
  input  logic        sck,
  input  logic        ws,
  input  logic        sd,
  output logic        smp_valid,
  output logic [$clog2(MAX_CH)-1:0] smp_chan,
  output logic [31:0] smp_data,
  output logic        fmt_err
);
  localparam int CH_W = $clog2(MAX_CH);

  logic        sck_q, primed, ws_prev, pend, active, framed, lvl;
  logic [31:0] shreg;
  logic [5:0]  bitcnt;
  logic [CH_W:0] wcnt;

  wire right_al = cfg[11];
  wire pol      = cfg[10];
  wire early    = cfg[9];
  wire multi    = cfg[8];
  wire unused_cfg = ^{cfg[15:12], cfg[7:4]};

  wire [5:0]  wlen     = {1'b0, cfg[3:0], 1'b0} + 6'd2;
  wire        rise     = sck & ~sck_q;
  wire        edge_now = primed && (ws != ws_prev);
  wire        bnd      = early ? pend : edge_now;
  wire        fstart   = bnd && (ws == pol);
  wire [31:0] shifted  = {shreg[30:0], sd};

  function automatic logic [31:0] sext(input logic [31:0] v, input logic [5:0] n);
    for (int i = 0; i < 32; i++)
      sext[i] = (6'(i) < n) ? v[i] : v[5'(n - 6'd1)];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; primed <= 1'b0; ws_prev <= 1'b0; pend <= 1'b0;
      active <= 1'b0; framed <= 1'b0; lvl <= 1'b0;
      shreg <= '0; bitcnt <= '0; wcnt <= '0;
      smp_valid <= 1'b0; smp_chan <= '0; smp_data <= '0; fmt_err <= 1'b0;
    end else begin
      sck_q     <= sck;
      smp_valid <= 1'b0;
      if (rise) begin
        primed  <= 1'b1;
        ws_prev <= ws;
        pend    <= edge_now;
        if (!multi) begin
          if (bnd) begin
            if (active) begin
              smp_valid <= 1'b1;
              smp_data  <= sext(shreg, wlen);
              smp_chan  <= (lvl == pol) ? '0 : CH_W'(1);
            end
            active <= 1'b1;
            lvl    <= ws;
            shreg  <= {31'b0, sd};
            bitcnt <= 6'd1;
          end else if (right_al || bitcnt < wlen) begin
            shreg <= shifted;
            if (bitcnt != 6'd63) bitcnt <= bitcnt + 6'd1;
          end
        end else begin
          if (fstart) begin
            if (framed && wcnt[0]) fmt_err <= 1'b1;
            framed <= 1'b1;
            wcnt   <= '0;
            shreg  <= {31'b0, sd};
            bitcnt <= 6'd1;
          end else if (framed) begin
            if (bitcnt == wlen - 6'd1) begin
              if (wcnt == (CH_W+1)'(MAX_CH)) begin
                fmt_err <= 1'b1;
              end else begin
                smp_valid <= 1'b1;
                smp_data  <= sext(shifted, wlen);
                smp_chan  <= wcnt[CH_W-1:0];
                wcnt      <= wcnt + 1'b1;
              end
              bitcnt <= '0;
              shreg  <= '0;
            end else begin
              shreg  <= shifted;
              bitcnt <= bitcnt + 6'd1;
            end
          end
        end
      end
    end
  end

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  a_r2_sext16: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(cfg[3:0]) == 4'd7) |-> (smp_data[31:16] == {16{smp_data[15]}}));
  a_r7_stereo_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !$past(cfg[8])) |-> (smp_chan <= CH_W'(1)));
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [15:0] cfg = '0;
  logic smp_valid, fmt_err;
  logic [2:0] smp_chan;
  logic [31:0] smp_data;
  int nchk = 0, nfail = 0, nc = 0;
  logic [31:0] cd [64];
  logic [2:0]  cc [64];

  always #10 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (.clk(clk), .rst_n(rst_n), .cfg(cfg), .sck(sck),
    .ws(ws), .sd(sd), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .fmt_err(fmt_err));

  always @(negedge clk)
    if (smp_valid && nc < 64) begin cd[nc] = smp_data; cc[nc] = smp_chan; nc++; end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] mkcfg(input logic ra, input logic pol, input logic erl,
                                        input logic mul, input logic [3:0] wf);
    mkcfg = {4'b0, ra, pol, erl, mul, 4'b0, wf};
  endfunction

  function automatic logic [15:0] mval(input int w);
    mval = 16'h8421 ^ 16'(w * 32'h1357);
  endfunction

  task automatic restart(input logic [15:0] c);
    @(negedge clk); rst_n = 1'b0; cfg = c; sck = 1'b0; ws = 1'b0; sd = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1; nc = 0;
  endtask

  task automatic bitx(input logic w, input logic b);
    @(negedge clk); ws = w; sd = b;
    @(negedge clk); sck = 1'b1;
    @(negedge clk);
    @(negedge clk); sck = 1'b0;
  endtask

  task automatic send_slot(input logic lv, input logic nx, input logic erl,
                           input logic [31:0] d, input int n, input int len, input logic ra);
    for (int i = 0; i < len; i++) begin
      int k;
      logic b;
      k = ra ? i - (len - n) : i;
      b = (k >= 0 && k < n) ? d[n-1-k] : 1'b1;
      bitx((erl && i == len - 1) ? nx : lv, b);
    end
  endtask

  task automatic send_frame(input int k, input int base, input logic erl, input logic lft);
    int total;
    total = k * 16;
    for (int j = 0; j < total; j++) begin
      int jj;
      logic [15:0] v;
      jj = erl ? j + 1 : j;
      v = mval(base + j / 16);
      bitx((jj < 16 || jj >= total) ? lft : ~lft, v[15 - (j % 16)]);
    end
  endtask

  task automatic stereo_case(input string req, input logic ra, input logic pol, input logic erl,
                             input logic [3:0] wf, input int len,
                             input logic [31:0] dl, input logic [31:0] dr,
                             input logic [31:0] el, input logic [31:0] er);
    int n;
    n = 2 * wf + 2;
    restart(mkcfg(ra, pol, erl, 1'b0, wf));
    send_slot(~pol, pol, erl, 32'h0, n, 4, ra);
    send_slot(pol, ~pol, erl, dl, n, len, ra);
    send_slot(~pol, pol, erl, dr, n, len, ra);
    chk({req, " no sample before slot closes"}, 32'(nc), 32'd1);
    bitx(pol, 1'b0);
    repeat (3) @(negedge clk);
    chk({req, " count"}, 32'(nc), 32'd2);
    chk({req, " ch0 data"}, cd[0], el);
    chk({req, " ch0 index"}, 32'(cc[0]), 32'd0);
    chk({req, " ch1 data"}, cd[1], er);
    chk({req, " ch1 index"}, 32'(cc[1]), 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R11 valid", 32'(smp_valid), 32'd0);
    chk("R11 chan", 32'(smp_chan), 32'd0);
    chk("R11 data", smp_data, 32'd0);
    chk("R11 err", 32'(fmt_err), 32'd0);
  endtask

  task automatic t_stereo_start16;
    stereo_case("R1 R3 R5 R6 R7 start-aligned 16b", 1'b0, 1'b0, 1'b0, 4'd7, 20,
                32'h8001, 32'h1234, 32'hFFFF8001, 32'h00001234);
  endtask

  task automatic t_stereo_end18;
    stereo_case("R2 R4 R5 R6 end-aligned 18b early", 1'b1, 1'b1, 1'b1, 4'd8, 24,
                32'h20000, 32'h0ABCD, 32'hFFFE0000, 32'h0000ABCD);
  endtask

  task automatic t_stereo_32;
    stereo_case("R1 full 32b", 1'b0, 1'b0, 1'b0, 4'd15, 32,
                32'hDEADBEEF, 32'h12345678, 32'hDEADBEEF, 32'h12345678);
    stereo_case("R4 end-aligned 16b in 32 slot", 1'b1, 1'b0, 1'b0, 4'd7, 32,
                32'h7FFF, 32'hC000, 32'h00007FFF, 32'hFFFFC000);
  endtask

  task automatic t_multi6;
    restart(mkcfg(1'b0, 1'b0, 1'b0, 1'b1, 4'd7));
    repeat (3) bitx(1'b1, 1'b1);
    send_frame(6, 0, 1'b0, 1'b0);
    send_frame(6, 6, 1'b0, 1'b0);
    bitx(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 multichannel count", 32'(nc), 32'd12);
    for (int i = 0; i < 12; i++) begin
      logic [15:0] v;
      v = mval(i);
      chk("R8 word data", cd[i], {{16{v[15]}}, v});
      chk("R8 word index", 32'(cc[i]), 32'(i % 6));
    end
    chk("R10 even frame no error", 32'(fmt_err), 32'd0);
  endtask

  task automatic t_multi_over;
    restart(mkcfg(1'b0, 1'b1, 1'b1, 1'b1, 4'd7));
    repeat (3) bitx(1'b0, 1'b0);
    bitx(1'b1, 1'b0);
    send_frame(10, 0, 1'b1, 1'b1);
    bitx(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 only eight words kept", 32'(nc), 32'd8);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = mval(i);
      chk("R9 kept word data", cd[i], {{16{v[15]}}, v});
      chk("R9 kept word index", 32'(cc[i]), 32'(i));
    end
    chk("R9 error on ninth word", 32'(fmt_err), 32'd1);
    repeat (20) bitx(1'b0, 1'b0);
    chk("R10 error sticky", 32'(fmt_err), 32'd1);
  endtask

  task automatic t_multi_odd;
    restart(mkcfg(1'b0, 1'b0, 1'b0, 1'b1, 4'd7));
    repeat (3) bitx(1'b1, 1'b0);
    send_frame(3, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 three words out", 32'(nc), 32'd3);
    chk("R10 no error before next frame", 32'(fmt_err), 32'd0);
    bitx(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 odd count flagged", 32'(fmt_err), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset;
    t_stereo_start16;
    t_stereo_end18;
    t_stereo_32;
    t_multi6;
    t_multi_over;
    t_multi_odd;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule